// File: doc/BRIEF.md
# Gray-Timestamp Pixel Hit Capture

This block keeps one free-running 7-bit time count and sends it, Gray-coded, to every pixel cell of a column pair. Each pixel takes its discriminator output through a two-flop synchronizer and then looks for edges. On a rising edge it stores the current Gray time as its leading stamp. On the falling edge that follows, it stores the trailing stamp and flags itself as holding a hit.

A flagged pixel shows two values until the column scanner clears it. The first is its leading-edge time, converted to binary. The second is its charge, given as time over threshold: the trailing stamp minus the leading stamp, modulo 128. If a pixel that is still flagged sees a new rising edge, it drops that pulse and keeps its stored hit. A shared, saturating overflow count records each pulse dropped this way.

Top module: `gray_hit_capture`

## Requirements
- R1: While reset is held, the time output is 0, no pixel is flagged, and the overflow count is 0.
- R2: After reset, the binary value of the Gray time goes up by one on every clock edge. Exactly one bit of the time output changes per clock.
- R3: The time count wraps from 127 to 0. The Gray output goes from 1000000 to 0000000.
- R4: A pixel's leading stamp is the binary value of the time output in the cycle after the second rising clock edge that follows the discriminator going high. The trailing stamp follows the same rule for the discriminator going low.
- R5: A pixel stays unflagged while only its rising edge has been captured. It becomes flagged one clock after its trailing stamp is taken.
- R6: The charge output equals (trailing − leading) mod 128. This holds across a wrap of the time count.
- R7: A rising edge on a flagged pixel changes neither its flag nor its stored values, and adds one to the overflow count.
- R8: A clear pulse on a flagged pixel makes it unflagged at the next clock. A clear on a pixel that is not flagged has no effect.
- R9: The overflow count saturates at its maximum (255 by default) and stays there.
- R10: Pixels work independently. Simultaneous pulses on different pixels are each captured correctly. Drops on several pixels in the same cycle add their total to the overflow count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_i | input | NPIX | Discriminator output of each pixel (asynchronous) |
| clr_i | input | NPIX | Clear request from the scanner, one bit per pixel |
| time_gray_o | output | TW | Gray-coded time broadcast to the array |
| hit_o | output | NPIX | Pixel holds a complete, unread hit |
| lead_o | output | NPIX*TW | Binary leading-edge time, pixel p at bits [p*TW +: TW] |
| tot_o | output | NPIX*TW | Time over threshold, pixel p at bits [p*TW +: TW] |
| ovf_o | output | OVW | Saturating count of pulses dropped on flagged pixels |

## Verification
The assertions assume a single reset at the start. They also assume that each high or low level of the discriminator lasts at least one full clock, so that every level passes through the synchronizer. The stimulus changes the discriminator and clear inputs only on falling clock edges and keeps every level for two cycles or more. It raises a clear on a flagged pixel, and on an armed pixel, only where it checks the rule for that case.

// File: rtl/gray_hit_capture.sv
module gray_hit_capture #(
  parameter int NPIX = 4,
  parameter int TW   = 7,
  parameter int OVW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIX-1:0]   disc_i,
  input  logic [NPIX-1:0]   clr_i,
  output logic [TW-1:0]     time_gray_o,
  output logic [NPIX-1:0]   hit_o,
  output logic [NPIX*TW-1:0] lead_o,
  output logic [NPIX*TW-1:0] tot_o,
  output logic [OVW-1:0]    ovf_o
);
  localparam int SW = OVW + $clog2(NPIX + 1);
  localparam logic [OVW-1:0] OMAX = '1;

  typedef enum logic [1:0] {P_IDLE, P_ARM, P_TAG} pst_t;

  function automatic logic [TW-1:0] g2b(input logic [TW-1:0] g);
    logic [TW-1:0] b;
    b[TW-1] = g[TW-1];
    for (int k = TW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  logic [TW-1:0]   cnt;
  logic [NPIX-1:0] s1, s2, s3, ign;
  logic [OVW-1:0]  ovf_q;
  logic [SW-1:0]   osum;
  logic            run_q;

  assign time_gray_o = cnt ^ (cnt >> 1);
  assign ovf_o = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; s1 <= '0; s2 <= '0; s3 <= '0; run_q <= 1'b0; ovf_q <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      s1 <= disc_i; s2 <= s1; s3 <= s2;
      run_q <= 1'b1;
      ovf_q <= (osum > SW'(OMAX)) ? OMAX : osum[OVW-1:0];
    end
  end

  always_comb begin
    osum = SW'(ovf_q);
    for (int k = 0; k < NPIX; k++) osum = osum + SW'(ign[k]);
  end

  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    pst_t st;
    logic [TW-1:0] ld_g, tr_g;
    logic rise, fall;
    assign rise = s2[i] & ~s3[i];
    assign fall = ~s2[i] & s3[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st <= P_IDLE; ld_g <= '0; tr_g <= '0;
      end else begin
        case (st)
          P_IDLE: if (rise) begin ld_g <= time_gray_o; st <= P_ARM; end
          P_ARM:  if (fall) begin tr_g <= time_gray_o; st <= P_TAG; end
          P_TAG:  if (clr_i[i]) st <= P_IDLE;
          default: st <= P_IDLE;
        endcase
      end
    end

    assign ign[i] = (st == P_TAG) & rise & ~clr_i[i];
    assign hit_o[i] = (st == P_TAG);
    assign lead_o[i*TW +: TW] = g2b(ld_g);
    assign tot_o[i*TW +: TW]  = g2b(tr_g) - g2b(ld_g);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o[i] && !clr_i[i] |=> hit_o[i] && $stable(lead_o[i*TW +: TW]) && $stable(tot_o[i*TW +: TW]));
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o[i] && clr_i[i] |=> !hit_o[i]);
  end

  p_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> $countones(time_gray_o ^ $past(time_gray_o)) == 1);
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && time_gray_o == '0 |-> $past(time_gray_o) == TW'(1 << (TW - 1)));
  p_ovf_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ovf_o >= $past(ovf_o));
  p_ovf_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o == OMAX |=> ovf_o == OMAX);
endmodule

// File: tb/sim_gray_hit_capture.sv
module sim_gray_hit_capture;
  localparam int CLK_NS = 10;
  localparam int NPIX = 4;
  localparam int TW = 7;
  localparam int OVW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPIX-1:0] disc = '0;
  logic [NPIX-1:0] clr = '0;
  logic [TW-1:0] tg;
  logic [NPIX-1:0] hit;
  logic [NPIX*TW-1:0] lead, tot;
  logic [OVW-1:0] ovf;

  int n_chk = 0, n_bad = 0, exp_ovf = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  gray_hit_capture #(.NPIX(NPIX), .TW(TW), .OVW(OVW)) u0 (
    .clk(clk), .rst_n(rst_n), .disc_i(disc), .clr_i(clr), .time_gray_o(tg),
    .hit_o(hit), .lead_o(lead), .tot_o(tot), .ovf_o(ovf));

  function automatic int gbin(input logic [TW-1:0] g);
    int v = 0;
    logic b = 1'b0;
    for (int k = TW - 1; k >= 0; k--) begin
      b = b ^ g[k];
      v = v * 2 + int'(b);
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ld(input int p); return int'(lead[p*TW +: TW]); endfunction
  function automatic int tt(input int p); return int'(tot[p*TW +: TW]); endfunction

  // called at a negedge; returns at negedge N0+w+2
  task automatic pulse(input int p, input int w, output int lb, output int tb);
    disc[p] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    lb = gbin(tg);
    repeat (w - 2) @(negedge clk);
    disc[p] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    tb = gbin(tg);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(tg == '0, "R1 time", int'(tg), 0);
    check(hit == '0, "R1 hit", int'(hit), 0);
    check(ovf == '0, "R1 ovf", int'(ovf), 0);
  endtask

  task automatic t_count();
    int prev = gbin(tg);
    logic [TW-1:0] pg = tg;
    bit seen_wrap = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      check(gbin(tg) == (prev + 1) % 128, "R2 step", gbin(tg), (prev + 1) % 128);
      check($countones(tg ^ pg) == 1, "R2 one bit", $countones(tg ^ pg), 1);
      if (prev == 127) begin
        seen_wrap = 1;
        check(pg == 7'b1000000 && tg == 7'b0, "R3 wrap", int'(tg), 0);
      end
      prev = gbin(tg); pg = tg;
    end
    check(seen_wrap, "R3 seen", 0, 1);
  endtask

  task automatic t_basic();
    int lb, tb;
    pulse(0, 6, lb, tb);
    check(hit[0] == 1'b0, "R5 not yet", int'(hit[0]), 0);
    @(negedge clk);
    check(hit[0] == 1'b1, "R5 flagged", int'(hit[0]), 1);
    check(ld(0) == lb, "R4 lead", ld(0), lb);
    check(tt(0) == ((tb - lb) & 127), "R6 tot", tt(0), (tb - lb) & 127);
    check(tt(0) == 6, "R6 width", tt(0), 6);
  endtask

  task automatic t_overflow();
    int lb, tb, keep_l, keep_t;
    keep_l = ld(0); keep_t = tt(0);
    pulse(0, 4, lb, tb);
    @(negedge clk);
    exp_ovf++;
    check(hit[0] == 1'b1, "R7 still flagged", int'(hit[0]), 1);
    check(ld(0) == keep_l, "R7 lead kept", ld(0), keep_l);
    check(tt(0) == keep_t, "R7 tot kept", tt(0), keep_t);
    check(int'(ovf) == exp_ovf, "R7 ovf", int'(ovf), exp_ovf);
  endtask

  task automatic t_clear();
    int lb, tb;
    clr[0] = 1'b1; @(negedge clk); clr[0] = 1'b0;
    check(hit[0] == 1'b0, "R8 cleared", int'(hit[0]), 0);
    // clear on an armed, unflagged pixel has no effect
    disc[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    lb = gbin(tg);
    @(negedge clk); clr[1] = 1'b1; @(negedge clk); clr[1] = 1'b0;
    @(negedge clk); disc[1] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    tb = gbin(tg);
    @(negedge clk);
    check(hit[1] == 1'b1, "R8 ignored clear", int'(hit[1]), 1);
    check(ld(1) == lb, "R8 lead kept", ld(1), lb);
    check(tt(1) == ((tb - lb) & 127), "R8 tot", tt(1), (tb - lb) & 127);
    clr[1] = 1'b1; @(negedge clk); clr[1] = 1'b0;
  endtask

  task automatic t_wrap_tot();
    int lb, tb;
    while (gbin(tg) != 115) @(negedge clk);
    pulse(1, 20, lb, tb);
    @(negedge clk);
    check(lb > tb, "R6 crossed wrap", lb, tb);
    check(tt(1) == 20, "R6 wrap tot", tt(1), 20);
    check(ld(1) == lb, "R4 wrap lead", ld(1), lb);
  endtask

  task automatic t_multi();
    int l2, t2, l3, t3, d0, d1, d2, d3;
    fork
      pulse(2, 5, l2, t2);
      pulse(3, 9, l3, t3);
    join
    @(negedge clk);
    check(hit[3:2] == 2'b11, "R10 both flagged", int'(hit[3:2]), 3);
    check(ld(2) == l2 && ld(3) == l3, "R10 leads", ld(3), l3);
    check(tt(2) == 5, "R10 tot p2", tt(2), 5);
    check(tt(3) == 9, "R10 tot p3", tt(3), 9);
    fork
      pulse(2, 3, d0, d1);
      pulse(3, 3, d2, d3);
    join
    @(negedge clk);
    exp_ovf += 2;
    check(int'(ovf) == exp_ovf, "R10 double ovf", int'(ovf), exp_ovf);
  endtask

  task automatic t_saturate();
    int a, b;
    for (int k = 0; k < 260; k++) begin
      pulse(2, 2, a, b);
      exp_ovf = (exp_ovf + 1 > 255) ? 255 : exp_ovf + 1;
    end
    @(negedge clk);
    check(int'(ovf) == 255 && exp_ovf == 255, "R9 saturated", int'(ovf), 255);
    check(hit[2] == 1'b1, "R9 p2 kept", int'(hit[2]), 1);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_count();
    t_basic();
    t_overflow();
    t_clear();
    t_wrap_tot();
    t_multi();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule